// File: doc/BRIEF.md
# I2C Master Start-Condition Controller

This block turns a software request for a start condition into correct line activity on an I2C bus, or into a refusal when that request cannot be honoured. It accepts a one-cycle register write carrying a start bit and a stop bit. It then weighs the write against the current bus situation: whether the bus is free, whether another master owns it, and whether this master is parked in its wait state after a byte. From that it either generates a start at once, arms a repeated start that is released together with the wait, holds the request until the bus becomes free, or rejects it and raises a flag.

The block drives open-drain enables for SDA and SCL. Each phase of the start waveform lasts a run-time hold count measured in system clocks. A small line monitor watches the synchronised bus lines for start and stop conditions, so the block knows by itself whether a third party holds the bus. Byte transfer, acknowledge generation and stop generation belong to neighbouring logic. That logic owns the lines whenever this block leaves its enables low.

Top module: `i2c_start_ctrl`

## Requirements
- R1: With the bus free and no transfer owned by this master, an accepted start write pulls SDA low while SCL stays released for `hold_cycles` clocks (a value of 0 counts as 1). The block then drives both lines low for exactly one clock, with `start_done` high in that clock, and then releases both lines.
- R2: The readback `start_bit` reads 1 from the clock after an accepted write until the start completes, and 0 otherwise. While `start_bit` is 0 and the interface is enabled, both line enables are 0.
- R3: A write with both the start bit and the stop bit set is ignored: no start is made and `start_bit` stays 0.
- R4: While `enable` is 0, `start_bit` reads 0, writes are ignored, and any pending or running start is dropped with both lines released on the next clock.
- R5: `arb_lost` or `release_cmd` cancels a pending or running start on the next clock, and releases the lines. Either one also wins over a start write in the same cycle.
- R6: With `reserve_off` = 0, a start written while a third party holds the bus makes `start_bit` read 1 without any line activity. The start is then produced automatically once the bus becomes free.
- R7: With `reserve_off` = 1, a start written while a third party holds the bus sets `refused` and leaves `start_bit` at 0 with no line activity. `refused` clears on the next accepted start write, or when the interface is disabled.
- R8: A start accepted while this master owns the bus produces no line activity until `wait_release` pulses. It then runs the following phases, each `hold_cycles` clocks long: SDA released with SCL low, then both released, then SDA low with SCL released. After those it gives the one-clock SCL-low handover of R1.
- R9: While this master owns the bus as a transmitter (`is_receiver` = 0), a start write is accepted only when `master_wait` = 1 and `ninth_done` = 1. Otherwise it is ignored.
- R10: While this master owns the bus as a receiver (`is_receiver` = 1), a start write is accepted only when `master_wait` = 1, `ack_en` = 0 and `last_rx` = 1. Otherwise it is ignored.
- R11: A start write made while `start_bit` is already 1 is ignored. In particular, it does not restart the hold count of the phase in progress.
- R12: The bus counts as free after reset. It becomes busy when SDA falls while SCL is high, and free again when SDA rises while SCL is high, as seen after `SYNC_STAGES` synchroniser flops.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Interface enable |
| reserve_off | input | 1 | 1 = refuse starts on a busy bus, 0 = reserve them |
| wr_en | input | 1 | Control register write strobe |
| wr_start | input | 1 | Start bit of the write |
| wr_stop | input | 1 | Stop bit of the write |
| release_cmd | input | 1 | Exit-from-communication command |
| arb_lost | input | 1 | Arbitration lost pulse |
| master_own | input | 1 | This master currently owns a transfer |
| master_wait | input | 1 | Master is in its wait state |
| ninth_done | input | 1 | Wait follows the ninth clock (transmit) |
| is_receiver | input | 1 | Current transfer is master receive |
| ack_en | input | 1 | Acknowledge generation enabled |
| last_rx | input | 1 | Final byte has been received |
| wait_release | input | 1 | Pulse that releases the master wait |
| hold_cycles | input | HOLD_W | Hold count per waveform phase, in clocks |
| sda_in | input | 1 | Sampled SDA line |
| scl_in | input | 1 | Sampled SCL line |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| start_bit | output | 1 | Start trigger readback |
| refused | output | 1 | Start request refused on busy bus |
| start_done | output | 1 | One-clock pulse at the end of a start |

## Verification
Two functions can land in the same clock: a start write arriving in the same cycle as a cancel (`arb_lost` or `release_cmd`), and a second start write arriving while the hold count of a running start advances. The first case is provoked by raising `arb_lost` together with a start write on a free bus. It passes only if `start_bit` stays 0 and SDA is never pulled. The second case is provoked by repeating the write during the SDA-low phase. It is judged by measuring that phase at the ports: the phase must still last exactly `hold_cycles` clocks.

// File: rtl/i2c_stc_pkg.sv
package i2c_stc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RESV    = 3'd1,
        ST_RS_WAIT = 3'd2,
        ST_REL_SDA = 3'd3,
        ST_REL_SCL = 3'd4,
        ST_GEN_SDA = 3'd5,
        ST_SCL_LOW = 3'd6
    } stc_state_e;

    typedef struct packed {
        stc_state_e state;
        logic       pend;
        logic       refused;
    } stc_regs_t;

endpackage

// File: rtl/i2c_stc_bus_mon.sv
module i2c_stc_bus_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_in,
    input  logic scl_in,
    output logic bus_busy
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sda_sync_q, sda_sync_d;
    logic [LAST:0] scl_sync_q, scl_sync_d;
    logic          sda_prev_q, sda_prev_d;
    logic          scl_prev_q, scl_prev_d;
    logic          busy_q, busy_d;
    logic          start_seen, stop_seen;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_comb begin
                sda_sync_d = sda_in;
                scl_sync_d = scl_in;
            end
        end else begin : g_chain
            always_comb begin
                sda_sync_d = {sda_sync_q[LAST-1:0], sda_in};
                scl_sync_d = {scl_sync_q[LAST-1:0], scl_in};
            end
        end
    endgenerate

    always_comb begin
        sda_prev_d = sda_sync_q[LAST];
        scl_prev_d = scl_sync_q[LAST];
        start_seen = sda_prev_q && !sda_sync_q[LAST] && scl_prev_q && scl_sync_q[LAST];
        stop_seen  = !sda_prev_q && sda_sync_q[LAST] && scl_prev_q && scl_sync_q[LAST];
        busy_d     = busy_q;
        if (start_seen) begin
            busy_d = 1'b1;
        end else if (stop_seen) begin
            busy_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_sync_q <= '1;
            scl_sync_q <= '1;
            sda_prev_q <= 1'b1;
            scl_prev_q <= 1'b1;
            busy_q     <= 1'b0;
        end else begin
            sda_sync_q <= sda_sync_d;
            scl_sync_q <= scl_sync_d;
            sda_prev_q <= sda_prev_d;
            scl_prev_q <= scl_prev_d;
            busy_q     <= busy_d;
        end
    end

    assign bus_busy = busy_q;
endmodule

// File: rtl/i2c_stc_hold_timer.sv
module i2c_stc_hold_timer #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [HOLD_W-1:0] hold,
    output logic              expire
);
    logic [HOLD_W-1:0] cnt_q, cnt_d;
    logic [HOLD_W-1:0] last_val;

    always_comb begin
        last_val = (hold == '0) ? '0 : hold - 1'b1;
        expire   = (cnt_q >= last_val);
        if (restart) begin
            cnt_d = '0;
        end else if (expire) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/i2c_stc_req_filter.sv
module i2c_stc_req_filter (
    input  logic enable,
    input  logic wr_en,
    input  logic wr_start,
    input  logic wr_stop,
    input  logic pending,
    input  logic master_own,
    input  logic master_wait,
    input  logic ninth_done,
    input  logic is_receiver,
    input  logic ack_en,
    input  logic last_rx,
    output logic req_ok
);
    logic write_valid;
    logic window_ok;

    always_comb begin
        write_valid = enable && wr_en && wr_start && !wr_stop && !pending;
        if (!master_own) begin
            window_ok = 1'b1;
        end else if (is_receiver) begin
            window_ok = master_wait && !ack_en && last_rx;
        end else begin
            window_ok = master_wait && ninth_done;
        end
        req_ok = write_valid && window_ok;
    end
endmodule

// File: rtl/i2c_start_ctrl.sv
module i2c_start_ctrl
    import i2c_stc_pkg::*;
#(
    parameter int HOLD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              reserve_off,
    input  logic              wr_en,
    input  logic              wr_start,
    input  logic              wr_stop,
    input  logic              release_cmd,
    input  logic              arb_lost,
    input  logic              master_own,
    input  logic              master_wait,
    input  logic              ninth_done,
    input  logic              is_receiver,
    input  logic              ack_en,
    input  logic              last_rx,
    input  logic              wait_release,
    input  logic [HOLD_W-1:0] hold_cycles,
    input  logic              sda_in,
    input  logic              scl_in,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic              start_bit,
    output logic              refused,
    output logic              start_done
);
    stc_regs_t r_q, r_d;
    logic      bus_busy;
    logic      req_ok;
    logic      hold_expire;
    logic      timer_restart;

    i2c_stc_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_in   (sda_in),
        .scl_in   (scl_in),
        .bus_busy (bus_busy)
    );

    i2c_stc_req_filter u_filt (
        .enable      (enable),
        .wr_en       (wr_en),
        .wr_start    (wr_start),
        .wr_stop     (wr_stop),
        .pending     (r_q.pend),
        .master_own  (master_own),
        .master_wait (master_wait),
        .ninth_done  (ninth_done),
        .is_receiver (is_receiver),
        .ack_en      (ack_en),
        .last_rx     (last_rx),
        .req_ok      (req_ok)
    );

    i2c_stc_hold_timer #(.HOLD_W(HOLD_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (timer_restart),
        .hold    (hold_cycles),
        .expire  (hold_expire)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_ok) begin
                    if (master_own) begin
                        r_d.state   = ST_RS_WAIT;
                        r_d.pend    = 1'b1;
                        r_d.refused = 1'b0;
                    end else if (!bus_busy) begin
                        r_d.state   = ST_GEN_SDA;
                        r_d.pend    = 1'b1;
                        r_d.refused = 1'b0;
                    end else if (!reserve_off) begin
                        r_d.state   = ST_RESV;
                        r_d.pend    = 1'b1;
                        r_d.refused = 1'b0;
                    end else begin
                        r_d.refused = 1'b1;
                    end
                end
            end
            ST_RESV: begin
                if (!bus_busy) begin
                    r_d.state = ST_GEN_SDA;
                end
            end
            ST_RS_WAIT: begin
                if (wait_release) begin
                    r_d.state = ST_REL_SDA;
                end
            end
            ST_REL_SDA: begin
                if (hold_expire) begin
                    r_d.state = ST_REL_SCL;
                end
            end
            ST_REL_SCL: begin
                if (hold_expire) begin
                    r_d.state = ST_GEN_SDA;
                end
            end
            ST_GEN_SDA: begin
                if (hold_expire) begin
                    r_d.state = ST_SCL_LOW;
                end
            end
            ST_SCL_LOW: begin
                r_d.state = ST_IDLE;
                r_d.pend  = 1'b0;
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.pend  = 1'b0;
            end
        endcase

        if (!enable || arb_lost || release_cmd) begin
            r_d.state = ST_IDLE;
            r_d.pend  = 1'b0;
        end
        if (!enable) begin
            r_d.refused = 1'b0;
        end

        timer_restart = (r_d.state != r_q.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.pend    <= 1'b0;
            r_q.refused <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe     = (r_q.state == ST_GEN_SDA) || (r_q.state == ST_SCL_LOW);
    assign scl_oe     = (r_q.state == ST_REL_SDA) || (r_q.state == ST_SCL_LOW);
    assign start_bit  = r_q.pend && enable;
    assign refused    = r_q.refused;
    assign start_done = (r_q.state == ST_SCL_LOW);
endmodule

// File: rtl/i2c_stc_checker.sv
module i2c_stc_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic reserve_off,
    input logic wr_en,
    input logic wr_start,
    input logic wr_stop,
    input logic release_cmd,
    input logic arb_lost,
    input logic sda_oe,
    input logic scl_oe,
    input logic start_bit,
    input logic refused,
    input logic start_done
);
    assert_sda_falls_scl_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_oe);

    assert_scl_follows_sda_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_oe) && sda_oe) |-> $past(sda_oe));

    assert_done_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_done |=> !start_bit);

    assert_idle_lines_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !start_bit) |-> (!sda_oe && !scl_oe));

    assert_both_bits_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_start && wr_stop && !start_bit) |=> !start_bit);

    assert_disable_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!start_bit && !sda_oe && !scl_oe));

    assert_abort_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost || release_cmd) |=> (!start_bit && !sda_oe && !scl_oe));

    assert_refuse_needs_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refused) |-> ($past(reserve_off) && !start_bit));
endmodule

bind i2c_start_ctrl i2c_stc_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .reserve_off (reserve_off),
    .wr_en       (wr_en),
    .wr_start    (wr_start),
    .wr_stop     (wr_stop),
    .release_cmd (release_cmd),
    .arb_lost    (arb_lost),
    .sda_oe      (sda_oe),
    .scl_oe      (scl_oe),
    .start_bit   (start_bit),
    .refused     (refused),
    .start_done  (start_done)
);

// File: tb/tb_i2c_start_ctrl.sv
module tb_i2c_start_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1, reserve_off = 1'b0;
    logic       wr_en = 1'b0, wr_start = 1'b0, wr_stop = 1'b0;
    logic       release_cmd = 1'b0, arb_lost = 1'b0;
    logic       master_own = 1'b0, master_wait = 1'b0, ninth_done = 1'b0;
    logic       is_receiver = 1'b0, ack_en = 1'b1, last_rx = 1'b0;
    logic       wait_release = 1'b0;
    logic [7:0] hold_cycles = 8'd3;
    logic       tp_sda = 1'b1, tp_scl = 1'b1;
    logic       sda_oe, scl_oe, start_bit, refused, start_done;
    logic       sda_line, scl_line;
    int         tests = 0, fails = 0;

    assign sda_line = tp_sda & ~sda_oe;
    assign scl_line = tp_scl & ~scl_oe;

    always #5 clk = ~clk;

    i2c_start_ctrl dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .reserve_off(reserve_off),
        .wr_en(wr_en), .wr_start(wr_start), .wr_stop(wr_stop),
        .release_cmd(release_cmd), .arb_lost(arb_lost), .master_own(master_own),
        .master_wait(master_wait), .ninth_done(ninth_done), .is_receiver(is_receiver),
        .ack_en(ack_en), .last_rx(last_rx), .wait_release(wait_release),
        .hold_cycles(hold_cycles), .sda_in(sda_line), .scl_in(scl_line),
        .sda_oe(sda_oe), .scl_oe(scl_oe), .start_bit(start_bit),
        .refused(refused), .start_done(start_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write(input logic s, input logic p);
        wr_en = 1'b1; wr_start = s; wr_stop = p;
        @(negedge clk);
        wr_en = 1'b0; wr_start = 1'b0; wr_stop = 1'b0;
    endtask

    task automatic measure(input logic es, input logic ec, output int n);
        n = 0;
        while (sda_oe == es && scl_oe == ec && n < 300) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic tp_start();
        tp_sda = 1'b0; wait_n(6);
    endtask

    task automatic tp_stop();
        tp_sda = 1'b1; wait_n(6);
    endtask

    task automatic free_bus();
        tp_start(); tp_stop();
    endtask

    task automatic finish_tail(input string tag);
        check(sda_oe && scl_oe && start_done, tag, {sda_oe, scl_oe, start_done}, 7);
        @(negedge clk);
        check(!start_bit && !sda_oe && !scl_oe, tag, {start_bit, sda_oe, scl_oe}, 0);
    endtask

    task automatic t_reset();
        check(!start_bit && !refused && !sda_oe && !scl_oe && !start_done, "R2 reset",
              {start_bit, refused, sda_oe, scl_oe, start_done}, 0);
    endtask

    task automatic t_free_start();
        int n;
        hold_cycles = 8'd3;
        write(1'b1, 1'b0);
        check(start_bit == 1'b1, "R2 readback", start_bit, 1);
        measure(1'b1, 1'b0, n);
        check(n == 3, "R1 sda low hold", n, 3);
        finish_tail("R1 handover");
        free_bus();
        hold_cycles = 8'd0;
        write(1'b1, 1'b0);
        measure(1'b1, 1'b0, n);
        check(n == 1, "R1 zero hold", n, 1);
        finish_tail("R1 zero tail");
        free_bus();
        hold_cycles = 8'd3;
    endtask

    task automatic t_both_bits();
        write(1'b1, 1'b1);
        wait_n(2);
        check(!start_bit && !sda_oe, "R3 start+stop ignored", {start_bit, sda_oe}, 0);
    endtask

    task automatic t_disable();
        int n;
        enable = 1'b0;
        write(1'b1, 1'b0);
        wait_n(2);
        check(!start_bit && !sda_oe, "R4 write while disabled", {start_bit, sda_oe}, 0);
        enable = 1'b1;
        hold_cycles = 8'd10;
        write(1'b1, 1'b0);
        wait_n(2);
        check(sda_oe == 1'b1, "R4 start running", sda_oe, 1);
        enable = 1'b0;
        @(negedge clk);
        check(!start_bit && !sda_oe && !scl_oe, "R4 disable aborts", {start_bit, sda_oe, scl_oe}, 0);
        enable = 1'b1;
        hold_cycles = 8'd3;
        wait_n(6);
        write(1'b1, 1'b0);
        measure(1'b1, 1'b0, n);
        check(n == 3, "R12 bus free after own sda release", n, 3);
        finish_tail("R12 tail");
        free_bus();
    endtask

    task automatic t_cancel();
        arb_lost = 1'b1;
        write(1'b1, 1'b0);
        arb_lost = 1'b0;
        wait_n(2);
        check(!start_bit && !sda_oe, "R5 arb_lost beats write", {start_bit, sda_oe}, 0);
        tp_start();
        reserve_off = 1'b0;
        write(1'b1, 1'b0);
        check(start_bit == 1'b1, "R5 pending before arb", start_bit, 1);
        arb_lost = 1'b1; @(negedge clk); arb_lost = 1'b0;
        check(!start_bit, "R5 arb_lost clears", start_bit, 0);
        write(1'b1, 1'b0);
        release_cmd = 1'b1; @(negedge clk); release_cmd = 1'b0;
        check(!start_bit, "R5 release clears", start_bit, 0);
        tp_stop();
        check(!sda_oe, "R5 no late start", sda_oe, 0);
    endtask

    task automatic t_reserve();
        int n;
        tp_start();
        reserve_off = 1'b0;
        write(1'b1, 1'b0);
        wait_n(8);
        check(start_bit && !sda_oe && !scl_oe, "R6 held while busy (R12)",
              {start_bit, sda_oe, scl_oe}, 4);
        tp_sda = 1'b1;
        n = 0;
        while (!sda_oe && n < 30) begin n++; @(negedge clk); end
        check(sda_oe && !scl_oe, "R6 start after bus free", {sda_oe, scl_oe}, 2);
        measure(1'b1, 1'b0, n);
        check(n == 3, "R6 reserved start hold", n, 3);
        finish_tail("R6 tail");
        free_bus();
    endtask

    task automatic t_refuse();
        tp_start();
        reserve_off = 1'b1;
        write(1'b1, 1'b0);
        wait_n(3);
        check(refused && !start_bit && !sda_oe, "R7 refused", {refused, start_bit, sda_oe}, 4);
        reserve_off = 1'b0;
        write(1'b1, 1'b0);
        check(!refused && start_bit, "R7 flag clears on accept", {refused, start_bit}, 1);
        release_cmd = 1'b1; @(negedge clk); release_cmd = 1'b0;
        tp_stop();
    endtask

    task automatic t_tx_window();
        int n;
        master_own = 1'b1; is_receiver = 1'b0; master_wait = 1'b1; ninth_done = 1'b0;
        write(1'b1, 1'b0);
        check(!start_bit, "R9 ack period ignored", start_bit, 0);
        ninth_done = 1'b1; master_wait = 1'b0;
        write(1'b1, 1'b0);
        check(!start_bit, "R9 no wait ignored", start_bit, 0);
        master_wait = 1'b1;
        hold_cycles = 8'd5;
        write(1'b1, 1'b0);
        check(start_bit, "R9 accepted after ninth", start_bit, 1);
        wait_n(3);
        check(!sda_oe && !scl_oe, "R8 idle until wait release", {sda_oe, scl_oe}, 0);
        wait_release = 1'b1; @(negedge clk); wait_release = 1'b0;
        measure(1'b0, 1'b1, n);
        check(n == 5, "R8 sda release phase", n, 5);
        measure(1'b0, 1'b0, n);
        check(n == 5, "R8 scl release phase", n, 5);
        measure(1'b1, 1'b0, n);
        check(n == 5, "R8 sda low phase", n, 5);
        finish_tail("R8 tail");
        hold_cycles = 8'd3;
        master_wait = 1'b0; ninth_done = 1'b0;
    endtask

    task automatic t_rx_window();
        is_receiver = 1'b1; master_wait = 1'b1; ack_en = 1'b1; last_rx = 1'b1;
        write(1'b1, 1'b0);
        check(!start_bit, "R10 ack enabled ignored", start_bit, 0);
        ack_en = 1'b0; last_rx = 1'b0;
        write(1'b1, 1'b0);
        check(!start_bit, "R10 not final ignored", start_bit, 0);
        last_rx = 1'b1;
        write(1'b1, 1'b0);
        check(start_bit, "R10 accepted", start_bit, 1);
        release_cmd = 1'b1; @(negedge clk); release_cmd = 1'b0;
        master_own = 1'b0; is_receiver = 1'b0; master_wait = 1'b0; ack_en = 1'b1; last_rx = 1'b0;
        free_bus();
    endtask

    task automatic t_rewrite();
        int m;
        hold_cycles = 8'd4;
        write(1'b1, 1'b0);
        write(1'b1, 1'b0);
        measure(1'b1, 1'b0, m);
        check(1 + m == 4, "R11 rewrite ignored", 1 + m, 4);
        finish_tail("R11 tail");
        free_bus();
        hold_cycles = 8'd3;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait_n(3);
        t_reset();
        rst_n = 1'b1;
        wait_n(3);
        t_reset();
        t_free_start();
        t_both_bits();
        t_disable();
        t_cancel();
        t_reserve();
        t_refuse();
        t_tx_window();
        t_rx_window();
        t_rewrite();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule